// File: doc/BRIEF.md
# Half-Bridge Output Gating with Supply Lockout and Transient Blanking

This block sits in the logic domain of a half-bridge gate driver. It sits between the two logic commands, one for the high-side switch and one for the low-side switch, and the two output commands that go on to the level shifter and output stages. In normal running each output copies its own input in phase, one clock later. No interlock is applied, so both outputs may be high together.

Three protection sources gate the outputs. The first is a low-side supply under-voltage flag, which forces both outputs low while it is asserted. The second is a floating-supply under-voltage flag, which forces only the high-side output low. The third is a negative switch-node excursion flag. The flag must stay asserted for more than a set number of cycles before it counts. It then blanks the high-side output for a fixed hold window. After a floating-supply lockout or a blanking hold, the high-side output stays disarmed until a new rising edge of the high-side command is seen with both conditions clear. The two under-voltage flags arrive already filtered and carry their own hysteresis. The qualification and hold lengths are parameters given in clock cycles.

Top module: `hb_gate_lockout`

## Requirements
- R1: ho_o and lo_o copy hin_i and lin_i in phase, registered on the rising clock edge at which the input is sampled. For ho_o this applies while the high side is armed.
- R2: When uv_low_i is sampled high at an edge, both ho_o and lo_o are low after that edge.
- R3: Once uv_low_i is sampled low again, both outputs return to copying their inputs at the next edge. A low-side lockout does not disarm the high side, so no new hin_i edge is needed.
- R4: When hin_i and lin_i are both high and no lockout is active, ho_o and lo_o are both high. There is no interlock.
- R5: When uv_float_i is sampled high at an edge, ho_o is low after that edge and lo_o keeps copying lin_i.
- R6: After uv_float_i clears, ho_o stays low until a rising edge of hin_i is seen. A rising edge means hin_i is sampled low at one edge and high at the next. ho_o goes high at the edge that samples the rising edge.
- R7: If neg_vs_i is sampled high at more than QUAL_CYC consecutive edges, ho_o is low after the qualifying edge and after each of the following HOLD_CYC edges. A run of QUAL_CYC or fewer high samples has no effect.
- R8: A rising edge of hin_i sampled during a floating lockout or a blanking hold does not re-arm the high side. The first edge at which a rising edge can re-arm it is the (HOLD_CYC+1)-th edge after the qualifying edge.
- R9: A new qualifying transient during a hold restarts the full HOLD_CYC window from its own qualifying edge.
- R10: During reset both outputs are low. After reset the high side is disarmed, and a hin_i that is already high at the first edge does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hin_i | input | 1 | High-side switch command |
| lin_i | input | 1 | Low-side switch command |
| uv_low_i | input | 1 | Low-side supply under-voltage flag, 1 = under-voltage |
| uv_float_i | input | 1 | Floating supply under-voltage flag, 1 = under-voltage |
| neg_vs_i | input | 1 | Negative switch-node excursion flag, 1 = excursion present |
| ho_o | output | 1 | High-side output command |
| lo_o | output | 1 | Low-side output command |

## Verification
The critical overlap is a rising edge of hin_i landing in the same cycle that a blanking hold or a floating lockout ends or begins. A qualifying transient can also fire in the very cycle that would otherwise re-arm the high side. The directed part places a rising edge exactly on the last hold edge and another on the first edge after it, and expects rejection and acceptance respectively. It also places a rising edge inside a restarted hold at the point where the first hold would have ended. A long pseudo-random sweep then mixes bursty excursion flags with both lockout flags and edges on both commands. Every cycle is judged against a reference model that tracks the hold end as an absolute cycle stamp and the excursion as a run length.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  localparam int unsigned DEF_QUAL_CYC = 5;    // 50 ns at 100 MHz
  localparam int unsigned DEF_HOLD_CYC = 450;  // 4.5 us at 100 MHz

  typedef enum logic {
    ARM_OFF = 1'b0,
    ARM_ON  = 1'b1
  } arm_state_e;

  localparam int unsigned CH_LO = 0;
  localparam int unsigned CH_HI = 1;
  localparam int unsigned N_CH  = 2;

endpackage

// File: rtl/hbg_blank.sv
module hbg_blank #(
  parameter int unsigned QUAL_CYC = hbg_pkg::DEF_QUAL_CYC,
  parameter int unsigned HOLD_CYC = hbg_pkg::DEF_HOLD_CYC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic neg_i,
  output logic fire_o,
  output logic hold_o
);

  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);
  localparam logic [HW-1:0] HMAX = HW'(HOLD_CYC);

  logic [QW-1:0] qcnt_q;
  logic [HW-1:0] hcnt_q;

  // qcnt_q: consecutive earlier high samples, saturating
  assign fire_o = neg_i && (qcnt_q == QMAX);
  assign hold_o = (hcnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qcnt_q <= '0;
    end else if (!neg_i) begin
      qcnt_q <= '0;
    end else if (qcnt_q != QMAX) begin
      qcnt_q <= qcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
    end else if (fire_o) begin
      hcnt_q <= HMAX;
    end else if (hcnt_q != '0) begin
      hcnt_q <= hcnt_q - 1'b1;
    end
  end

  p_hold_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (hcnt_q == HMAX));

  p_hold_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !fire_o) |=> (hcnt_q == $past(hcnt_q) - 1'b1));

  p_short_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !neg_i |=> !fire_o || (QUAL_CYC == 0));

endmodule

// File: rtl/hbg_arm.sv
module hbg_arm
  import hbg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  input  logic block_i,
  output logic rise_o,
  output logic armed_o
);

  logic       prev_q;
  arm_state_e state_q;
  arm_state_e state_d;

  assign rise_o  = in_i & ~prev_q;
  assign armed_o = (state_q == ARM_ON);

  always_comb begin
    state_d = state_q;
    if (block_i) begin
      state_d = ARM_OFF;
    end else if (rise_o) begin
      state_d = ARM_ON;
    end
  end

  // prev resets high: a level already high after reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b1;
      state_q <= ARM_OFF;
    end else begin
      prev_q  <= in_i;
      state_q <= state_d;
    end
  end

  p_arm_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_i |=> !armed_o);

  p_arm_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> ($past(in_i) && !$past(block_i)));

endmodule

// File: rtl/hb_gate_lockout.sv
module hb_gate_lockout
  import hbg_pkg::*;
#(
  parameter int unsigned QUAL_CYC = DEF_QUAL_CYC,
  parameter int unsigned HOLD_CYC = DEF_HOLD_CYC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hin_i,
  input  logic lin_i,
  input  logic uv_low_i,
  input  logic uv_float_i,
  input  logic neg_vs_i,
  output logic ho_o,
  output logic lo_o
);

  logic fire;
  logic hold;
  logic hs_block;
  logic rise;
  logic armed;
  logic [N_CH-1:0] cmd;
  logic [N_CH-1:0] en;
  logic [N_CH-1:0] out_q;

  hbg_blank #(
    .QUAL_CYC (QUAL_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_blank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .neg_i  (neg_vs_i),
    .fire_o (fire),
    .hold_o (hold)
  );

  // low-side lockout gates but does not disarm
  assign hs_block = uv_float_i | fire | hold;

  hbg_arm u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .in_i    (hin_i),
    .block_i (hs_block),
    .rise_o  (rise),
    .armed_o (armed)
  );

  assign cmd[CH_LO] = lin_i;
  assign cmd[CH_HI] = hin_i;
  assign en[CH_LO]  = ~uv_low_i;
  assign en[CH_HI]  = ~uv_low_i & ~hs_block & (armed | rise);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q[ch] <= 1'b0;
      end else begin
        out_q[ch] <= cmd[ch] & en[ch];
      end
    end
  end

  assign ho_o = out_q[CH_HI];
  assign lo_o = out_q[CH_LO];

  p_uv_low_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_low_i |=> !lo_o);

  p_uv_low_ho_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_low_i |=> !ho_o);

  p_lo_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uv_low_i |=> (lo_o == $past(lin_i)));

  p_float_ho_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_float_i |=> !ho_o);

  p_blank_ho_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire || hold) |=> !ho_o);

  p_ho_phase_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ho_o |-> $past(hin_i));

endmodule

// File: tb/hb_gate_lockout_tb_top.sv
module hb_gate_lockout_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int QUAL       = 5;
  localparam int HOLD       = 450;
  localparam int WDOG_CYC   = 100000;
  localparam int SWEEP_CYC  = 4000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hin_i = 1'b0, lin_i = 1'b0, uv_low_i = 1'b0, uv_float_i = 1'b0, neg_vs_i = 1'b0;
  logic ho_o, lo_o;

  int tests = 0;
  int fails = 0;

  // reference model state
  longint m_cyc = 0;
  longint m_hold_end = -1;
  int     m_run = 0;
  bit     m_armed = 1'b0;
  bit     m_prev = 1'b1;
  bit     m_ho = 1'b0;
  bit     m_lo = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  hb_gate_lockout #(
    .QUAL_CYC (QUAL),
    .HOLD_CYC (HOLD)
  ) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hin_i      (hin_i),
    .lin_i      (lin_i),
    .uv_low_i   (uv_low_i),
    .uv_float_i (uv_float_i),
    .neg_vs_i   (neg_vs_i),
    .ho_o       (ho_o),
    .lo_o       (lo_o)
  );

  task automatic m_step();
    bit fire, fblk, rise;
    m_cyc++;
    m_run = neg_vs_i ? m_run + 1 : 0;
    fire  = neg_vs_i && (m_run > QUAL);
    if (fire) m_hold_end = m_cyc + HOLD;
    fblk  = uv_float_i || fire || (m_cyc <= m_hold_end);
    rise  = hin_i && !m_prev;
    m_ho  = hin_i && !uv_low_i && !fblk && (m_armed || rise);
    if (fblk) m_armed = 1'b0;
    else if (rise) m_armed = 1'b1;
    m_prev = hin_i;
    m_lo  = lin_i && !uv_low_i;
  endtask

  task automatic cyc();
    m_step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string tag, input bit ho_e, input bit lo_e);
    tests++;
    if (ho_o !== ho_e || lo_o !== lo_e) begin
      fails++;
      $display("FAIL %s: ho=%b lo=%b expected ho=%b lo=%b at t=%0t",
               tag, ho_o, lo_o, ho_e, lo_e, $time);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(WDOG_CYC * CLK_PERIOD);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int a;
    hin_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R10 reset outputs low", 1'b0, 1'b0);
    rst_ni = 1'b1;

    // R10: hin high from reset is not an edge
    cyc(); chk("R10 no arm without edge", 1'b0, 1'b0);
    hin_i = 0; cyc();
    hin_i = 1; lin_i = 1; cyc(); chk("R1 R4 both follow high", 1'b1, 1'b1);
    lin_i = 0; cyc(); chk("R1 in phase hi only", 1'b1, 1'b0);

    // low-side lockout with hin held high
    lin_i = 1; uv_low_i = 1; cyc(); chk("R2 both forced low", 1'b0, 1'b0);
    cyc(); chk("R2 both stay low", 1'b0, 1'b0);
    uv_low_i = 0; cyc(); chk("R3 recover without edge", 1'b1, 1'b1);
    hin_i = 0; cyc(); chk("R1 in phase lo only", 1'b0, 1'b1);

    // floating lockout; edge during lockout ignored
    uv_float_i = 1; hin_i = 1; cyc(); chk("R5 ho low lo follows", 1'b0, 1'b1);
    lin_i = 0; cyc(); chk("R5 lo follows low", 1'b0, 1'b0);
    uv_float_i = 0; cyc(); chk("R6 R8 ho held after recovery", 1'b0, 1'b0);
    cyc(); chk("R6 still held", 1'b0, 1'b0);
    hin_i = 0; cyc();
    hin_i = 1; cyc(); chk("R6 re-armed by fresh edge", 1'b1, 1'b0);

    // short excursion: exactly QUAL samples
    neg_vs_i = 1;
    for (int i = 0; i < QUAL; i++) begin
      cyc(); chk("R7 short excursion ignored", 1'b1, 1'b0);
    end
    neg_vs_i = 0; cyc(); chk("R7 short excursion ignored", 1'b1, 1'b0);

    // qualified excursion: QUAL+1 samples, fire on last
    neg_vs_i = 1;
    for (int i = 0; i < QUAL; i++) cyc();
    chk("R7 not yet qualified", 1'b1, 1'b0);
    cyc(); chk("R7 blank at qualifying edge", 1'b0, 1'b0);
    neg_vs_i = 0;
    for (int i = 1; i <= HOLD - 2; i++) begin
      cyc(); chk("R7 blank during hold", 1'b0, 1'b0);
    end
    hin_i = 0; cyc();
    hin_i = 1; cyc(); chk("R8 edge on last hold edge ignored", 1'b0, 1'b0);
    cyc(); chk("R8 still disarmed after hold", 1'b0, 1'b0);
    hin_i = 0; cyc();
    hin_i = 1; cyc(); chk("R8 edge after hold re-arms", 1'b1, 1'b0);

    // restart of hold
    neg_vs_i = 1;
    for (int i = 0; i <= QUAL; i++) cyc();
    chk("R9 first fire", 1'b0, 1'b0);
    neg_vs_i = 0;
    for (int i = 0; i < 9; i++) cyc();
    neg_vs_i = 1;
    for (int i = 0; i <= QUAL; i++) cyc();
    chk("R9 second fire", 1'b0, 1'b0);
    neg_vs_i = 0;
    a = HOLD - QUAL - 10;
    for (int i = 1; i <= HOLD + 1; i++) begin
      hin_i = (i == a || i == HOLD) ? 1'b0 : 1'b1;
      cyc();
      if (i == a + 1) chk("R9 hold restarted, edge ignored", 1'b0, 1'b0);
      if (i == HOLD + 1) chk("R8 first edge after restarted hold", 1'b1, 1'b0);
    end

    // pseudo-random sweep against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < SWEEP_CYC; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hin_i      = lfsr[0];
      lin_i      = lfsr[1];
      uv_low_i   = (lfsr[4:2] == 3'd0);
      uv_float_i = (lfsr[7:5] == 3'd0);
      neg_vs_i   = ((i % 1000) < 120) ? (lfsr[9] | lfsr[10]) : (lfsr[9] & lfsr[10]);
      cyc();
      chk("sweep R1 R2 R5 R7", m_ho, m_lo);
    end

    summary();
    $finish;
  end

endmodule